// File: doc/BRIEF.md
# Single-Cycle 32-bit RISC Subset Core

This block is a 32-bit processor core that completes one instruction in each clock cycle. It runs register-to-register arithmetic and logic, word loads and stores, a branch taken when two registers are equal, and an unconditional jump. It holds a program counter, a 32-entry register file, an ALU, two decoders and two word-addressed memories: one for instructions and one for data.

Each instruction is fetched from the instruction memory and decoded. Its operands are read and the result is computed and written back, all in the same cycle. The main decoder sends a 2-bit class code to a second decoder. That second decoder uses the function field to choose a 3-bit ALU operation.

A test environment fills both memories through a preload port while reset is held, or while the core is paused. It then watches the program counter and the register-write debug outputs.

Top module: `sc_core`

## Requirements
- R1: Asserting `rst_n` low forces `dbg_pc` to 0 at once, without waiting for a clock edge. While the core is running, the PC advances by 4 on each rising edge unless a branch or jump is taken. The PC always stays word aligned.
- R2: Opcode 0 selects a register-register operation. The function field selects the operation: 32 is add, 34 is subtract, 36 is AND and 37 is OR. The result is written to the register named in bits 15..11. The sources are named in bits 25..21 and bits 20..16.
- R3: Function code 42 writes 1 to the destination when the sign bit of (first source minus second source) is 1. Otherwise it writes 0.
- R4: Opcode 35 loads a word into the register named in bits 20..16. The address is the base register plus the immediate in bits 15..0, sign-extended. The memory word index is taken from the address bits above bit 1.
- R5: Opcode 43 stores the register named in bits 20..16 to the same effective address. The store writes no register, so `dbg_wr_en` stays low.
- R6: Opcode 4 compares the two source registers. When they are equal, the next PC is PC+4 plus the sign-extended immediate shifted left by two. When they differ, the next PC is PC+4. Negative offsets branch backwards.
- R7: Opcode 2 jumps. The next PC is bits 31..28 of PC+4 followed by instruction bits 25..0 and two zero bits.
- R8: Register 0 always reads as zero. A write that targets register 0 is shown on the debug outputs but does not change it.
- R9: Any opcode other than 0, 2, 4, 35 and 43 writes nothing and advances the PC by 4.
- R10: While `load_en` is high, the word at `load_addr` is written on the rising edge. The target is the instruction memory when `load_sel`=0 and the data memory when `load_sel`=1. During that time the PC holds and no register or store write takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset; the PC goes to 0 |
| load_en | input | 1 | Preload write strobe; the core is paused while it is high |
| load_sel | input | 1 | Preload target: 0 for instruction memory, 1 for data memory |
| load_addr | input | LDW | Preload word index |
| load_data | input | 32 | Preload word |
| dbg_pc | output | 32 | Current program counter |
| dbg_wr_en | output | 1 | A register write takes place at the next rising edge |
| dbg_wr_reg | output | 5 | Destination register of that write |
| dbg_wr_data | output | 32 | Value being written |

## Verification
The hardest case to reach from the ports is a store whose effect can only be seen through a later load. A second such case is a write aimed at register 0, which has to be seen as having no effect.

The test program stores a computed value and then reloads it into a fresh register. That reload address uses a different base and offset from the store. Next, the program writes to register 0, and the instruction after it reads register 0 as an operand. The bench then checks the value that instruction writes back.

A taken branch jumps over filler instructions. A jump then lands on a backward branch that loops on itself, so the bench sees a PC that does not move.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam logic [5:0] OPC_ALU  = 6'd0;
  localparam logic [5:0] OPC_JMP  = 6'd2;
  localparam logic [5:0] OPC_BEQ  = 6'd4;
  localparam logic [5:0] OPC_LDW  = 6'd35;
  localparam logic [5:0] OPC_STW  = 6'd43;

  localparam logic [5:0] FN_ADD = 6'd32;
  localparam logic [5:0] FN_SUB = 6'd34;
  localparam logic [5:0] FN_AND = 6'd36;
  localparam logic [5:0] FN_OR  = 6'd37;
  localparam logic [5:0] FN_SLT = 6'd42;

  localparam logic [2:0] AOP_AND = 3'b000;
  localparam logic [2:0] AOP_OR  = 3'b001;
  localparam logic [2:0] AOP_ADD = 3'b010;
  localparam logic [2:0] AOP_SUB = 3'b110;
  localparam logic [2:0] AOP_SLT = 3'b111;

  localparam logic [1:0] CLS_MEM = 2'b00;
  localparam logic [1:0] CLS_CMP = 2'b01;
  localparam logic [1:0] CLS_FN  = 2'b10;

  typedef struct packed {
    logic       dst_rd;
    logic       branch;
    logic       jump;
    logic       mem_rd;
    logic       mem_to_reg;
    logic       mem_wr;
    logic       alu_imm;
    logic       reg_wr;
    logic [1:0] alu_cls;
  } ctrl_t;
endpackage

// File: rtl/sc_ctrl.sv
module sc_ctrl
  import sc_pkg::*;
(
  input  logic [5:0] opcode,
  output ctrl_t      ctl
);
  always_comb begin
    ctl = '0;
    ctl.alu_cls = CLS_MEM;
    case (opcode)
      OPC_ALU: begin
        ctl.dst_rd  = 1'b1;
        ctl.reg_wr  = 1'b1;
        ctl.alu_cls = CLS_FN;
      end
      OPC_LDW: begin
        ctl.mem_rd     = 1'b1;
        ctl.mem_to_reg = 1'b1;
        ctl.alu_imm    = 1'b1;
        ctl.reg_wr     = 1'b1;
      end
      OPC_STW: begin
        ctl.mem_wr  = 1'b1;
        ctl.alu_imm = 1'b1;
      end
      OPC_BEQ: begin
        ctl.branch  = 1'b1;
        ctl.alu_cls = CLS_CMP;
      end
      OPC_JMP: ctl.jump = 1'b1;
      default: ctl = '0;
    endcase
  end
endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [1:0]   cls,
  input  logic [5:0]   funct,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] res,
  output logic         zero
);
  logic [2:0]   aop;
  logic [W-1:0] diff;

  always_comb begin
    case (cls)
      CLS_CMP: aop = AOP_SUB;
      CLS_FN: begin
        case (funct)
          FN_SUB:  aop = AOP_SUB;
          FN_AND:  aop = AOP_AND;
          FN_OR:   aop = AOP_OR;
          FN_SLT:  aop = AOP_SLT;
          default: aop = AOP_ADD;
        endcase
      end
      default: aop = AOP_ADD;
    endcase
  end

  assign diff = a - b;

  always_comb begin
    case (aop)
      AOP_AND: res = a & b;
      AOP_OR:  res = a | b;
      AOP_SUB: res = diff;
      AOP_SLT: res = {{(W-1){1'b0}}, diff[W-1]};
      default: res = a + b;
    endcase
  end

  assign zero = (res == '0);
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int W     = 32,
  parameter int NREGS = 32
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(NREGS)-1:0] waddr,
  input  logic [W-1:0]             wdata,
  input  logic [$clog2(NREGS)-1:0] raddr_a,
  input  logic [$clog2(NREGS)-1:0] raddr_b,
  output logic [W-1:0]             rdata_a,
  output logic [W-1:0]             rdata_b
);
  logic [W-1:0] regs [NREGS];

  always_ff @(posedge clk) begin
    if (we && (waddr != '0)) regs[waddr] <= wdata;
  end

  assign rdata_a = (raddr_a == '0) ? '0 : regs[raddr_a];
  assign rdata_b = (raddr_b == '0) ? '0 : regs[raddr_b];
endmodule

// File: rtl/sc_wordmem.sv
module sc_wordmem #(
  parameter int W     = 32,
  parameter int WORDS = 64,
  localparam int AW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_pkg::*;
#(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64,
  localparam int IAW = $clog2(IMEM_WORDS),
  localparam int DAW = $clog2(DMEM_WORDS),
  localparam int LDW = (IAW > DAW) ? IAW : DAW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load_en,
  input  logic           load_sel,
  input  logic [LDW-1:0] load_addr,
  input  logic [31:0]    load_data,
  output logic [31:0]    dbg_pc,
  output logic           dbg_wr_en,
  output logic [4:0]     dbg_wr_reg,
  output logic [31:0]    dbg_wr_data
);
  logic [31:0] pc_q, pc_nxt, pc_plus4, br_tgt, jmp_tgt;
  logic [31:0] instr, imm_sext, rs_val, rt_val, alu_b, alu_res, dmem_rd, wb_data;
  logic [4:0]  wr_reg;
  logic        alu_zero, run, rf_we, dm_we;
  ctrl_t       ctl;

  assign run = rst_n & ~load_en;

  // instruction memory
  sc_wordmem #(.W(32), .WORDS(IMEM_WORDS)) u_imem (
    .clk   (clk),
    .we    (load_en & ~load_sel),
    .waddr (load_addr[IAW-1:0]),
    .wdata (load_data),
    .raddr (pc_q[IAW+1:2]),
    .rdata (instr)
  );

  sc_ctrl u_ctrl (.opcode(instr[31:26]), .ctl(ctl));

  assign imm_sext = {{16{instr[15]}}, instr[15:0]};
  assign wr_reg   = ctl.dst_rd ? instr[15:11] : instr[20:16];
  assign rf_we    = ctl.reg_wr & run;

  sc_regfile #(.W(32), .NREGS(32)) u_rf (
    .clk     (clk),
    .we      (rf_we),
    .waddr   (wr_reg),
    .wdata   (wb_data),
    .raddr_a (instr[25:21]),
    .raddr_b (instr[20:16]),
    .rdata_a (rs_val),
    .rdata_b (rt_val)
  );

  assign alu_b = ctl.alu_imm ? imm_sext : rt_val;

  sc_alu #(.W(32)) u_alu (
    .cls   (ctl.alu_cls),
    .funct (instr[5:0]),
    .a     (rs_val),
    .b     (alu_b),
    .res   (alu_res),
    .zero  (alu_zero)
  );

  // data memory: preload path has priority, stores only while running
  logic [DAW-1:0] dm_waddr;
  logic [31:0]    dm_wdata;
  assign dm_we    = (load_en & load_sel) | (ctl.mem_wr & run);
  assign dm_waddr = load_en ? load_addr[DAW-1:0] : alu_res[DAW+1:2];
  assign dm_wdata = load_en ? load_data : rt_val;

  sc_wordmem #(.W(32), .WORDS(DMEM_WORDS)) u_dmem (
    .clk   (clk),
    .we    (dm_we),
    .waddr (dm_waddr),
    .wdata (dm_wdata),
    .raddr (alu_res[DAW+1:2]),
    .rdata (dmem_rd)
  );

  assign wb_data = (ctl.mem_to_reg & ctl.mem_rd) ? dmem_rd : alu_res;

  // next-state logic for the PC
  assign pc_plus4 = pc_q + 32'd4;
  assign br_tgt   = pc_plus4 + {imm_sext[29:0], 2'b00};
  assign jmp_tgt  = {pc_plus4[31:28], instr[25:0], 2'b00};

  always_comb begin
    if (ctl.jump)                    pc_nxt = jmp_tgt;
    else if (ctl.branch && alu_zero) pc_nxt = br_tgt;
    else                             pc_nxt = pc_plus4;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pc_q <= '0;
    else if (!load_en) pc_q <= pc_nxt;
  end

  assign dbg_pc      = pc_q;
  assign dbg_wr_en   = rf_we;
  assign dbg_wr_reg  = wr_reg;
  assign dbg_wr_data = wb_data;

  logic unused_bits;
  assign unused_bits = ^{instr[10:6], alu_res, pc_q, load_addr};
endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        load_en,
  input logic [31:0] instr,
  input logic [31:0] pc,
  input logic [31:0] rs_val,
  input logic [31:0] rt_val,
  input logic        wr_en
);
  logic [5:0]  op;
  logic        known_op;
  logic [31:0] exp_br, exp_jmp, next_seq;

  assign op       = instr[31:26];
  assign known_op = (op == 6'd0) || (op == 6'd2) || (op == 6'd4) ||
                    (op == 6'd35) || (op == 6'd43);
  assign next_seq = pc + 32'd4;
  assign exp_br   = next_seq + {{14{instr[15]}}, instr[15:0], 2'b00};
  assign exp_jmp  = {next_seq[31:28], instr[25:0], 2'b00};

  // R1
  pc_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc[1:0] == 2'b00);

  // R5
  store_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 6'd43) |-> !wr_en);

  // R8
  zero_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (instr[25:21] == 5'd0) |-> (rs_val == 32'd0));

  // R9
  bad_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_en && !known_op) |=> (pc == $past(next_seq)));

  // R9
  bad_op_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !known_op |-> !wr_en);

  // R6
  beq_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_en && op == 6'd4 && rs_val == rt_val) |=> (pc == $past(exp_br)));

  // R7
  jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_en && op == 6'd2) |=> (pc == $past(exp_jmp)));

  // R10
  load_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> (pc == $past(pc)));
endmodule

bind sc_core sc_core_chk u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .load_en(load_en),
  .instr  (instr),
  .pc     (dbg_pc),
  .rs_val (rs_val),
  .rt_val (rt_val),
  .wr_en  (dbg_wr_en)
);

// File: tb/sc_core_test.sv
module sc_core_test;
  localparam int LDW   = 6;
  localparam int NPROG = 26;
  localparam int NROWS = 20;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           load_en, load_sel;
  logic [LDW-1:0] load_addr;
  logic [31:0]    load_data;
  logic [31:0]    dbg_pc, dbg_wr_data;
  logic           dbg_wr_en;
  logic [4:0]     dbg_wr_reg;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  sc_core uut (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_sel(load_sel),
    .load_addr(load_addr), .load_data(load_data), .dbg_pc(dbg_pc),
    .dbg_wr_en(dbg_wr_en), .dbg_wr_reg(dbg_wr_reg), .dbg_wr_data(dbg_wr_data)
  );

  always #5 clk = ~clk;

  function automatic logic [31:0] enc_r(logic [4:0] rs, logic [4:0] rt,
                                        logic [4:0] rd, logic [5:0] fn);
    return {6'd0, rs, rt, rd, 5'd0, fn};
  endfunction
  function automatic logic [31:0] enc_i(logic [5:0] op, logic [4:0] rs,
                                        logic [4:0] rt, logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction

  // expected per-cycle trace: pc, write enable, destination, value
  localparam logic [31:0] EXP_PC [NROWS] = '{
    32'd0, 32'd4, 32'd8, 32'd12, 32'd16, 32'd20, 32'd24, 32'd28, 32'd32, 32'd36,
    32'd40, 32'd44, 32'd48, 32'd52, 32'd56, 32'd68, 32'd72, 32'd76, 32'd100, 32'd100};
  localparam logic EXP_WE [NROWS] = '{
    1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1,
    1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0};
  localparam logic [4:0] EXP_RD [NROWS] = '{
    5'd1, 5'd2, 5'd3, 5'd4, 5'd5, 5'd6, 5'd7, 5'd8, 5'd0, 5'd9,
    5'd0, 5'd10, 5'd0, 5'd0, 5'd0, 5'd12, 5'd13, 5'd0, 5'd0, 5'd0};
  localparam logic [31:0] EXP_DAT [NROWS] = '{
    32'd7, 32'hFFFF_FFFD, 32'd4, 32'd10, 32'd5, 32'hFFFF_FFFF, 32'd1, 32'd0, 32'd0, 32'd10,
    32'd14, 32'd7, 32'd0, 32'd0, 32'd0, 32'd10, 32'h11, 32'd0, 32'd0, 32'd0};
  localparam string ROW_REQ [NROWS] = '{
    "R4", "R4", "R2", "R2", "R2", "R2", "R3", "R3", "R5", "R5",
    "R8", "R8", "R9", "R6", "R6", "R6", "R4", "R7", "R7", "R6"};

  task automatic check(string req, logic [31:0] act, logic [31:0] exp, string what);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic load_word(logic sel, int idx, logic [31:0] w);
    @(negedge clk);
    load_en = 1'b1; load_sel = sel; load_addr = idx[LDW-1:0]; load_data = w;
    @(negedge clk);
    load_en = 1'b0;
  endtask

  initial begin
    logic [31:0] prog [NPROG];
    rst_n = 1'b0; load_en = 1'b0; load_sel = 1'b0; load_addr = '0; load_data = '0;

    for (int k = 0; k < NPROG; k++) prog[k] = enc_r(5'd1, 5'd1, 5'd14, 6'd32);
    prog[0]  = enc_i(6'd35, 5'd0, 5'd1, 16'd4);
    prog[1]  = enc_i(6'd35, 5'd0, 5'd2, 16'd8);
    prog[2]  = enc_r(5'd1, 5'd2, 5'd3, 6'd32);
    prog[3]  = enc_r(5'd1, 5'd2, 5'd4, 6'd34);
    prog[4]  = enc_r(5'd1, 5'd2, 5'd5, 6'd36);
    prog[5]  = enc_r(5'd1, 5'd2, 5'd6, 6'd37);
    prog[6]  = enc_r(5'd2, 5'd1, 5'd7, 6'd42);
    prog[7]  = enc_r(5'd1, 5'd2, 5'd8, 6'd42);
    prog[8]  = enc_i(6'd43, 5'd0, 5'd4, 16'd12);
    prog[9]  = enc_i(6'd35, 5'd0, 5'd9, 16'd12);
    prog[10] = enc_r(5'd1, 5'd1, 5'd0, 6'd32);
    prog[11] = enc_r(5'd0, 5'd1, 5'd10, 6'd32);
    prog[12] = {6'd63, 26'h3FF_FFFF};
    prog[13] = enc_i(6'd4, 5'd1, 5'd2, 16'd5);
    prog[14] = enc_i(6'd4, 5'd4, 5'd9, 16'd2);
    prog[17] = enc_i(6'd35, 5'd4, 5'd12, 16'd2);
    prog[18] = enc_i(6'd35, 5'd3, 5'd13, 16'hFFFC);
    prog[19] = {6'd2, 26'd25};
    prog[25] = enc_i(6'd4, 5'd0, 5'd0, 16'hFFFF);

    repeat (2) @(negedge clk);
    // R1 reset state
    check("R1", dbg_pc, 32'd0, "pc in reset");
    for (int k = 0; k < NPROG; k++) load_word(1'b0, k, prog[k]);
    load_word(1'b1, 0, 32'h11);
    load_word(1'b1, 1, 32'd7);
    load_word(1'b1, 2, 32'hFFFF_FFFD);

    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < NROWS; i++) begin
      #1;
      check(ROW_REQ[i], dbg_pc, EXP_PC[i], $sformatf("pc row %0d", i));
      check(ROW_REQ[i], {31'd0, dbg_wr_en}, {31'd0, EXP_WE[i]}, $sformatf("wr_en row %0d", i));
      if (EXP_WE[i]) begin
        check(ROW_REQ[i], {27'd0, dbg_wr_reg}, {27'd0, EXP_RD[i]}, $sformatf("dest row %0d", i));
        check(ROW_REQ[i], dbg_wr_data, EXP_DAT[i], $sformatf("data row %0d", i));
      end
      @(negedge clk);
    end

    // R1 asynchronous reset away from the clock edge
    #2 rst_n = 1'b0;
    #1 check("R1", dbg_pc, 32'd0, "async reset pc");
    check("R10", {31'd0, dbg_wr_en}, 32'd0, "no write in reset");
    @(negedge clk);
    rst_n = 1'b1;

    // R10 preload while running: PC holds, no write shown
    @(negedge clk);
    check("R1", dbg_pc, 32'd4, "pc after one step");
    load_en = 1'b1; load_sel = 1'b0; load_addr = 6'd1;
    load_data = enc_r(5'd1, 5'd1, 5'd15, 6'd32);
    #1 check("R10", {31'd0, dbg_wr_en}, 32'd0, "no write while loading");
    @(negedge clk);
    load_en = 1'b0;
    #1 check("R10", dbg_pc, 32'd4, "pc held during load");
    check("R10", {27'd0, dbg_wr_reg}, 32'd15, "new instr dest");
    check("R10", dbg_wr_data, 32'd14, "new instr value");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule